// File: doc/BRIEF.md
# Chainable Serial Configuration Bit Reader

This block is the read side of a bit-serial configuration memory. It holds an image of `DEPTH_BITS` bits. Each rising edge of the configuration clock moves it one bit through that image, starting at address 0. Within each stored byte the most significant bit goes out first. Two inputs control the block. The first is an active-low chip enable. The second is a single pin that doubles as counter reset and output enable. A parameter sets which level of that pin means "reset".

When the image runs out, the block stops driving its data line and pulls its chip-enable-out low. The next reader in a chain takes that signal as its own chip enable, so any number of readers can feed one shared data line, one after another. A byte-wide synchronous load port fills the store. A synchronous active-high `rst` stands in for power-up clearing.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: While `rst` is high, the next edge clears the bit counter, drives `dout_en` low and drives `ceo_n` high. The next read starts again at bit 0.
- R2: While `ce_n` is low and the enable pin is at its active level, each edge outputs one bit on `dout` with `dout_en` high, in address order. Bit index 8k+j is bit (7-j) of stored byte k.
- R3: An edge that sees `ce_n` high drives `dout_en` low and leaves the counter unchanged. Once `ce_n` returns low, the read resumes with the next unread bit.
- R4: An edge that sees the enable pin at its reset level clears the counter, drives `dout_en` low and drives `ceo_n` high, whatever the level of `ce_n`.
- R5: The edge after the one that outputs the last bit drives `dout_en` low and, if `ce_n` is low, drives `ceo_n` low. `dout_en` and a low `ceo_n` never occur in the same cycle.
- R6: Once the image is exhausted and the enable pin stays active, `ceo_n` copies `ce_n` one edge later.
- R7: After a reset level on the enable pin, `ceo_n` stays high until every bit of the image has been read again.
- R8: With `RST_LOW`=1, a low pin means reset and a high pin means output enable. With `RST_LOW`=0, the two levels swap.
- R9: When each reader's `ceo_n` drives the next reader's `ce_n`, the shared line carries the first image and then the second, with exactly one idle cycle between them. At no time do two readers drive the line.
- R10: An edge with `load_en` high writes `load_byte` into store byte `load_addr`, in any read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous power-up clear, active high |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe_pin | input | 1 | Combined counter reset / output enable, polarity set by `RST_LOW` |
| load_en | input | 1 | Store write strobe |
| load_addr | input | $clog2(DEPTH_BITS/8) | Store byte address |
| load_byte | input | 8 | Store write data |
| dout | output | 1 | Serial data bit, valid while `dout_en` is high |
| dout_en | output | 1 | Data line drive enable |
| ceo_n | output | 1 | Chip enable out to the next reader, active low |

## Verification
A counter that skips or repeats a bit shows up on `dout` in the same cycle the bad address is read. A stale exhausted flag is also visible at the ports. Set too early, it lowers `ceo_n` while stream bits are still missing. Left set across a reset, it lets `ceo_n` fall before a full re-read. In a two-reader chain, either fault overlaps the drive windows or shifts the idle gap by at least one cycle. A chip-enable-out latch that ignores `ce_n` or the enable pin gives a wrong `ceo_n` one edge after that input changes.

// File: rtl/cfg_reader_pkg.sv
package cfg_reader_pkg;

  // Per-cycle read decision derived from the control pins.
  typedef struct packed {
    logic clr;  // clear counter, release line, raise chip-enable-out
    logic run;  // counting allowed this edge
  } rd_ctl_t;

  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cfg_reader_ctrl.sv
module cfg_reader_ctrl
  import cfg_reader_pkg::*;
#(
  parameter bit RST_LOW = 1'b1
) (
  input  logic    rst,
  input  logic    ce_n,
  input  logic    oe_pin,
  output rd_ctl_t ctl
);

  logic oe_active;

  // Normalise the pin to an active-high output enable.
  generate
    if (RST_LOW) begin : g_pol_low
      assign oe_active = oe_pin;
    end else begin : g_pol_high
      assign oe_active = ~oe_pin;
    end
  endgenerate

  always_comb begin
    ctl.clr = rst | ~oe_active;
    ctl.run = ~ctl.clr & ~ce_n;
  end

endmodule

// File: rtl/cfg_reader_cnt.sv
module cfg_reader_cnt
  import cfg_reader_pkg::*;
#(
  parameter int DEPTH_BITS = 4096,
  parameter int BIT_AW     = 12
) (
  input  logic              clk,
  input  rd_ctl_t           ctl,
  output logic [BIT_AW-1:0] addr,
  output logic              spent,
  output logic              step
);

  localparam logic [BIT_AW-1:0] LAST = BIT_AW'(DEPTH_BITS - 1);

  assign step = ctl.run & ~spent;

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      addr  <= '0;
      spent <= 1'b0;
    end else if (step) begin
      if (addr == LAST) begin
        addr  <= '0;
        spent <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_reader_store.sv
module cfg_reader_store #(
  parameter int NBYTES  = 512,
  parameter int BYTE_AW = 9,
  parameter int BIT_AW  = 12
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [BYTE_AW-1:0] wr_addr,
  input  logic [7:0]         wr_byte,
  input  logic               rd_en,
  input  logic [BIT_AW-1:0]  rd_addr,
  output logic               rd_bit
);

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  // Registered read; bit 7 of each byte leaves first.
  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= mem[rd_addr[BIT_AW-1:3]][~rd_addr[2:0]];
  end

endmodule

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader
  import cfg_reader_pkg::*;
#(
  parameter int DEPTH_BITS = 4096,
  parameter bit RST_LOW    = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ce_n,
  input  logic                            rst_oe_pin,
  input  logic                            load_en,
  input  logic [$clog2(DEPTH_BITS/8)-1:0] load_addr,
  input  logic [7:0]                      load_byte,
  output logic                            dout,
  output logic                            dout_en,
  output logic                            ceo_n
);

  localparam int NBYTES  = DEPTH_BITS / 8;
  localparam int BYTE_AW = addr_width(NBYTES);
  localparam int BIT_AW  = addr_width(DEPTH_BITS);

  rd_ctl_t           ctl;
  logic [BIT_AW-1:0] addr;
  logic              spent;
  logic              step;
  logic              rd_bit;
  logic              en_q;
  logic              ceo_q;

  cfg_reader_ctrl #(.RST_LOW(RST_LOW)) u_ctrl (
    .rst    (rst),
    .ce_n   (ce_n),
    .oe_pin (rst_oe_pin),
    .ctl    (ctl)
  );

  cfg_reader_cnt #(.DEPTH_BITS(DEPTH_BITS), .BIT_AW(BIT_AW)) u_cnt (
    .clk   (clk),
    .ctl   (ctl),
    .addr  (addr),
    .spent (spent),
    .step  (step)
  );

  cfg_reader_store #(.NBYTES(NBYTES), .BYTE_AW(BYTE_AW), .BIT_AW(BIT_AW)) u_store (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (load_addr),
    .wr_byte (load_byte),
    .rd_en   (step),
    .rd_addr (addr),
    .rd_bit  (rd_bit)
  );

  // Drive window and chip-enable-out handoff, both registered.
  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      en_q  <= 1'b0;
      ceo_q <= 1'b1;
    end else begin
      en_q  <= step;
      ceo_q <= ~(spent & ~ce_n);
    end
  end

  assign dout    = rd_bit & en_q;
  assign dout_en = en_q;
  assign ceo_n   = ceo_q;

endmodule

// File: rtl/cfg_reader_chk.sv
module cfg_reader_chk #(
  parameter bit RST_LOW = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic rst_oe_pin,
  input logic dout_en,
  input logic ceo_n
);

  logic oe_rst;
  assign oe_rst = RST_LOW ? ~rst_oe_pin : rst_oe_pin;

  // R3
  standby_release_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_en);

  // R4
  oe_reset_chk: assert property (@(posedge clk) disable iff (rst)
    oe_rst |=> (!dout_en && ceo_n));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> ceo_n);

  // R2
  drive_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!ce_n && !oe_rst));

  // R6
  ceo_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> $past(!ce_n && !oe_rst));

endmodule

bind cfg_bitstream_reader cfg_reader_chk #(.RST_LOW(RST_LOW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce_n       (ce_n),
  .rst_oe_pin (rst_oe_pin),
  .dout_en    (dout_en),
  .ceo_n      (ceo_n)
);

// File: tb/sim_cfg_bitstream_reader.sv
`timescale 1ns/1ps
module sim_cfg_bitstream_reader;

  localparam int DEPTH = 64;
  localparam int NB    = DEPTH / 8;
  localparam int AW    = $clog2(NB);

  // {reader select, byte address, byte value}
  localparam logic [16:0] LOADS [16] = '{
    {1'b0, 8'd0, 8'hA5}, {1'b0, 8'd1, 8'h0F}, {1'b0, 8'd2, 8'h81}, {1'b0, 8'd3, 8'hFF},
    {1'b0, 8'd4, 8'h00}, {1'b0, 8'd5, 8'h5A}, {1'b0, 8'd6, 8'hC3}, {1'b0, 8'd7, 8'h7E},
    {1'b1, 8'd0, 8'h96}, {1'b1, 8'd1, 8'hF0}, {1'b1, 8'd2, 8'h01}, {1'b1, 8'd3, 8'h80},
    {1'b1, 8'd4, 8'h3C}, {1'b1, 8'd5, 8'hE7}, {1'b1, 8'd6, 8'h24}, {1'b1, 8'd7, 8'hDB}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          ce_a_n = 1'b1;
  logic          pin_a = 1'b1;   // u0: high = output enable
  logic          pin_b = 1'b0;   // u1: low  = output enable
  logic          ld_a = 1'b0, ld_b = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_byte = '0;
  logic          d0, e0, c0, d1, e1, c1;

  int   total = 0, bad = 0;
  logic finished = 1'b0;
  logic [7:0] refm [2][NB];

  cfg_bitstream_reader #(.DEPTH_BITS(DEPTH), .RST_LOW(1'b1)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_a_n), .rst_oe_pin(pin_a),
    .load_en(ld_a), .load_addr(ld_addr), .load_byte(ld_byte),
    .dout(d0), .dout_en(e0), .ceo_n(c0));

  cfg_bitstream_reader #(.DEPTH_BITS(DEPTH), .RST_LOW(1'b0)) u1 (
    .clk(clk), .rst(rst), .ce_n(c0), .rst_oe_pin(pin_b),
    .load_en(ld_b), .load_addr(ld_addr), .load_byte(ld_byte),
    .dout(d1), .dout_en(e1), .ceo_n(c1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic ref_bit(input int s, input int k);
    return refm[s][k/8][7-(k%8)];
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int na = 0, nb = 0, mis_a = 0, mis_b = 0, clash = 0;
    int last_a = -1, first_b = -1, mis = 0, hi = 0;

    tick; tick;
    rst = 1'b0;
    // R1 reset state
    check(!e0 && !e1, "R1 dout_en after rst", e0 + e1, 0);
    check(c0 && c1, "R1 ceo_n after rst", c0 + c1, 2);

    // R10 fill both stores by walking the table
    for (int i = 0; i < 16; i++) begin
      ld_addr = LOADS[i][8+AW-1:8];
      ld_byte = LOADS[i][7:0];
      ld_a    = ~LOADS[i][16];
      ld_b    = LOADS[i][16];
      refm[LOADS[i][16]][LOADS[i][8+AW-1:8]] = LOADS[i][7:0];
      tick;
    end
    ld_a = 1'b0; ld_b = 1'b0;

    // R9 chained read of both images
    ce_a_n = 1'b0;
    for (int t = 0; t < 2 * DEPTH + 4; t++) begin
      tick;
      if (e0 && e1) clash++;
      if (e0) begin
        if (d0 !== ref_bit(0, na)) mis_a++;
        na++;
        last_a = t;
      end
      if (e1) begin
        if (d1 !== ref_bit(1, nb)) mis_b++;
        if (first_b < 0) first_b = t;
        nb++;
      end
    end
    check(clash == 0, "R9 both readers driving", clash, 0);
    check(na == DEPTH && mis_a == 0, "R2 first image bits (R10 content)", na - mis_a, DEPTH);
    check(nb == DEPTH && mis_b == 0, "R9 second image bits", nb - mis_b, DEPTH);
    check(first_b - last_a == 2, "R9 idle gap between images", first_b - last_a, 2);
    check(!c0, "R5 ceo_n low after last bit", c0, 0);
    check(!c1, "R5 second reader ceo_n low", c1, 0);

    // R6 ceo_n copies ce_n once exhausted
    ce_a_n = 1'b1;
    tick;
    check(c0, "R6 ceo_n follows ce_n high", c0, 1);
    ce_a_n = 1'b0;
    tick;
    check(!c0, "R6 ceo_n follows ce_n low", c0, 0);
    tick;

    // R8 inverted polarity on u1: high pin resets
    pin_b = 1'b1;
    tick;
    check(c1 && !e1, "R8 high pin resets u1", c1, 1);
    check(!c0, "R8 u0 unaffected", c0, 0);
    pin_b = 1'b0;
    tick;
    check(e1 && d1 == ref_bit(1, 0), "R8 low pin enables u1", e1, 1);

    // R4 / R7 reset with ce_n low, plus a rewrite of byte 0 (R10)
    ld_a = 1'b1; ld_addr = '0; ld_byte = 8'h3C; refm[0][0] = 8'h3C;
    pin_a = 1'b0; pin_b = 1'b1;
    tick;
    ld_a = 1'b0;
    check(!e0 && c0, "R4 reset level releases u0", {e0, c0}, 1);
    check(!e1 && c1, "R7 u1 ceo_n high after reset", {e1, c1}, 1);
    pin_a = 1'b1; pin_b = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick;
      if (!e0 || d0 !== ref_bit(0, k)) mis++;
    end
    check(mis == 0, "R4 restart at bit 0 (R10 rewrite)", mis, 0);
    check(c0, "R7 ceo_n high mid re-read", c0, 1);

    // R3 standby pauses and resumes
    ce_a_n = 1'b1;
    tick;
    check(!e0, "R3 ce_n high releases line", e0, 0);
    tick; tick;
    check(!e0, "R3 still released in standby", e0, 0);
    ce_a_n = 1'b0;
    tick;
    check(e0 && d0 == ref_bit(0, 5), "R3 resume at bit 5", e0, 1);

    // R7 ceo_n stays high until the full re-read completes
    for (int k = 6; k < DEPTH; k++) begin
      tick;
      if (!c0) hi++;
    end
    check(hi == 0, "R7 ceo_n early low", hi, 0);
    tick;
    check(!c0 && !e0, "R7 ceo_n low after full re-read", c0, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule